// File: doc/BRIEF.md
# Minimal Harvard Fetch-Execute Core

This block is a very small 8-bit processor core. Its program memory and its data memory sit on separate buses. Program memory holds 16-bit words and is addressed by word. Data memory holds bytes and is addressed by byte. The core keeps a 32-entry file of 8-bit registers, a word-wide program counter and a five-bit flag register.

The core recognises three operations:

- a register-to-register add,
- a load of an 8-bit constant into one of the upper sixteen registers,
- a two-word load that copies one byte of data memory into any register.

Every other word acts as a no-op. Both memories must answer combinationally, within the cycle in which the address is presented. There is no back-pressure: the core never waits on a memory, so the program and data ports are plain address/data pins and carry no valid/ready pair. Each register write is reported on a registered write-back port during the cycle after it is committed. This port is how the surrounding logic, or a bench, follows execution.

A single-word instruction completes in one cycle: the word at the program counter is fetched, decoded and executed, and the counter advances. The two-word load takes three cycles:

- cycle 1 fetches the opcode word,
- cycle 2 fetches and latches the address word,
- cycle 3 reads data memory and writes the register.

Top module: `hvc_core`

## Requirements
- R1: While `rst_n` is low and after its release, `prog_addr` is 0, `flags` is 0, `wb_en` and `data_rd` are 0, and every register holds 0. Adding R0 to R1 as the first instruction therefore writes 0 to R0 and sets only the Z flag.
- R2: A single-word instruction (add, load-constant or no-op) takes one clock, and `prog_addr` rises by exactly one. The program counter is PC_W = 14 bits wide and wraps from 0x3FFF to 0x0000.
- R3: Load-constant is any word whose bits 15:12 are 1110. The constant is bits 11:8 followed by bits 3:0. It is written to register 16 plus the value of bits 7:4.
- R4: The add is any word whose bits 15:10 are 000011. The destination register is bit 8 followed by bits 7:4. The source register is bit 9 followed by bits 3:0, so any of R0–R31 can be named. Rd + Rr modulo 256 is written to Rd, the source register keeps its value, and when Rd equals Rr the register doubles.
- R5: The add updates `flags`, where bit 0 = carry out of bit 7, bit 1 = result zero, bit 2 = result bit 7, bit 3 = two's-complement overflow, and bit 4 = carry out of bit 3.
- R6: The two-word load is a first word with bits 15:9 = 1001000 and bits 3:0 = 0000; its destination is bits 8:4. The following word is the 16-bit data address.
  - In the third cycle, `data_rd` is 1 and `data_addr` equals that address word.
  - The byte on `data_in` is written to the destination register.
  - `prog_addr` holds still during the third cycle and ends two above the first word.
- R7: Load-constant, the two-word load and no-ops leave `flags` unchanged. `flags` can change only together with a register write.
- R8: A word matching none of the three encodings writes no register, leaves `flags` as they were, and advances `prog_addr` by one.
- R9: `data_rd` is high only in the single data-read cycle of the two-word load, never two cycles in a row.
- R10: The clock after a register write, `wb_en` is 1, `wb_reg` gives the register index and `wb_val` gives the written byte. In all other cycles `wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | PC_W | Program memory word address (program counter) |
| prog_data | input | 16 | Word returned by program memory, same cycle |
| data_addr | output | 16 | Data memory byte address |
| data_rd | output | 1 | Data memory read strobe |
| data_in | input | 8 | Byte returned by data memory, same cycle |
| wb_en | output | 1 | A register was written at the last edge |
| wb_reg | output | 5 | Index of the register written |
| wb_val | output | 8 | Value written |
| flags | output | 5 | Flag register {H, V, N, Z, C} |

## Verification
Two things can meet in one cycle. The first is an add whose destination and source are the same register: that register is read twice and written in the same cycle, and the bench checks that the result is double the old value. The second is a value that has just been written, whether by a load-constant or by the data-read cycle of the two-word load, and is consumed by the very next add. The bench runs such chains back to back and compares each reported write and the flags against sums and flag values worked out by hand from the operands.

// File: rtl/hvc_pkg.sv
package hvc_pkg;
  localparam int unsigned IW     = 16;
  localparam int unsigned DW     = 8;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned NREGS  = 1 << RIDX_W;
  localparam int unsigned FLAG_W = 5;

  // flag bit positions
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_N = 2;
  localparam int unsigned FL_V = 3;
  localparam int unsigned FL_H = 4;

  typedef enum logic [1:0] {OP_NOP, OP_ADD, OP_LDI, OP_LDS} op_e;
  typedef enum logic [1:0] {PH_FETCH, PH_ADDR, PH_LOAD} phase_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rr;
    logic [DW-1:0]     imm;
  } dec_t;
endpackage

// File: rtl/hvc_decode.sv
module hvc_decode
  import hvc_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          dec
);
  always_comb begin
    dec.op  = OP_NOP;
    dec.rd  = word[8:4];
    dec.rr  = {word[9], word[3:0]};
    dec.imm = {word[11:8], word[3:0]};
    if (word[15:10] == 6'b000011) begin
      dec.op = OP_ADD;
    end else if (word[15:12] == 4'hE) begin
      dec.op = OP_LDI;
      dec.rd = {1'b1, word[7:4]};          // upper half of the file only
    end else if (word[15:9] == 7'b1001000 && word[3:0] == 4'h0) begin
      dec.op = OP_LDS;
    end
  end
endmodule

// File: rtl/hvc_alu.sv
module hvc_alu
  import hvc_pkg::*;
(
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [DW-1:0]     sum,
  output logic [FLAG_W-1:0] fl
);
  logic [DW:0] full;
  logic [4:0]  low;

  always_comb begin
    full      = {1'b0, a} + {1'b0, b};
    low       = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    sum       = full[DW-1:0];
    fl[FL_C]  = full[DW];
    fl[FL_Z]  = (full[DW-1:0] == '0);
    fl[FL_N]  = full[DW-1];
    fl[FL_V]  = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
    fl[FL_H]  = low[4];
  end
endmodule

// File: rtl/hvc_regfile.sv
module hvc_regfile
  import hvc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [RIDX_W-1:0] raddr_a,
  output logic [DW-1:0]     rdata_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [DW-1:0]     rdata_b
);
  logic [DW-1:0] q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) q[i] <= '0;
    end else if (we) begin
      q[waddr] <= wdata;
    end
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
endmodule

// File: rtl/hvc_core.sv
module hvc_core
  import hvc_pkg::*;
#(
  parameter int unsigned PC_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   prog_addr,
  input  logic [IW-1:0]     prog_data,
  output logic [IW-1:0]     data_addr,
  output logic              data_rd,
  input  logic [DW-1:0]     data_in,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [DW-1:0]     wb_val,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  phase_e            phase_q;
  logic [PC_W-1:0]   pc_q;
  logic [RIDX_W-1:0] dst_q;
  logic [IW-1:0]     daddr_q;
  logic [FLAG_W-1:0] flags_q;
  logic              wb_en_q;
  logic [RIDX_W-1:0] wb_reg_q;
  logic [DW-1:0]     wb_val_q;

  dec_t              dec;
  logic [DW-1:0]     rd_val, rr_val, alu_sum;
  logic [FLAG_W-1:0] alu_fl;
  logic              rf_we, take_flags;
  logic [RIDX_W-1:0] rf_waddr;
  logic [DW-1:0]     rf_wdata;

  hvc_decode u_dec (.word(prog_data), .dec(dec));

  hvc_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(dec.rd), .rdata_a(rd_val),
    .raddr_b(dec.rr), .rdata_b(rr_val)
  );

  hvc_alu u_alu (.a(rd_val), .b(rr_val), .sum(alu_sum), .fl(alu_fl));

  // write selection: execute phase of a single-word op, or the data-read phase
  always_comb begin
    rf_we      = 1'b0;
    rf_waddr   = dec.rd;
    rf_wdata   = '0;
    take_flags = 1'b0;
    case (phase_q)
      PH_FETCH: begin
        case (dec.op)
          OP_ADD: begin
            rf_we      = 1'b1;
            rf_wdata   = alu_sum;
            take_flags = 1'b1;
          end
          OP_LDI: begin
            rf_we    = 1'b1;
            rf_wdata = dec.imm;
          end
          default: ;
        endcase
      end
      PH_LOAD: begin
        rf_we    = 1'b1;
        rf_waddr = dst_q;
        rf_wdata = data_in;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_FETCH;
      pc_q     <= '0;
      dst_q    <= '0;
      daddr_q  <= '0;
      flags_q  <= '0;
      wb_en_q  <= 1'b0;
      wb_reg_q <= '0;
      wb_val_q <= '0;
    end else begin
      wb_en_q  <= rf_we;
      wb_reg_q <= rf_we ? rf_waddr : '0;
      wb_val_q <= rf_wdata;
      if (take_flags) flags_q <= alu_fl;
      case (phase_q)
        PH_FETCH: begin
          pc_q <= pc_q + PC_STEP;
          if (dec.op == OP_LDS) begin
            dst_q   <= dec.rd;
            phase_q <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          pc_q    <= pc_q + PC_STEP;
          daddr_q <= prog_data;
          phase_q <= PH_LOAD;
        end
        default: phase_q <= PH_FETCH;
      endcase
    end
  end

  assign prog_addr = pc_q;
  assign data_addr = daddr_q;
  assign data_rd   = (phase_q == PH_LOAD);
  assign wb_en     = wb_en_q;
  assign wb_reg    = wb_reg_q;
  assign wb_val    = wb_val_q;
  assign flags     = flags_q;
endmodule

// File: rtl/hvc_core_chk.sv
module hvc_core_chk #(
  parameter int unsigned PC_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] prog_addr,
  input logic            data_rd,
  input logic            wb_en,
  input logic [4:0]      flags
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> prog_addr == $past(prog_addr) + PC_W'(1));

  assert_load_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> prog_addr == $past(prog_addr));

  assert_load_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> wb_en);

  assert_read_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> !data_rd);

  assert_flags_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> wb_en);
endmodule

bind hvc_core hvc_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr),
  .data_rd(data_rd), .wb_en(wb_en), .flags(flags)
);

// File: tb/test_hvc_core.sv
module test_hvc_core;
  localparam int PC_W = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] prog_addr;
  logic [15:0]     prog_data;
  logic [15:0]     data_addr;
  logic            data_rd;
  logic [7:0]      data_in;
  logic            wb_en;
  logic [4:0]      wb_reg;
  logic [7:0]      wb_val;
  logic [4:0]      flags;

  int total = 0;
  int fails = 0;

  logic [15:0] pmem [64];

  always #5 clk = ~clk;

  function automatic logic [7:0] dval(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign prog_data = (prog_addr < PC_W'(64)) ? pmem[prog_addr[5:0]] : 16'h0000;
  assign data_in   = dval(data_addr);

  hvc_core #(.PC_W(PC_W)) i_hvc_core (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
    .data_addr(data_addr), .data_rd(data_rd), .data_in(data_in),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val), .flags(flags)
  );

  function automatic logic [15:0] w_add(int d, int r);
    return {6'b000011, r[4], d[4], d[3:0], r[3:0]};
  endfunction
  function automatic logic [15:0] w_ldi(int d, logic [7:0] k);
    return {4'hE, k[7:4], d[3:0], k[3:0]};
  endfunction
  function automatic logic [15:0] w_lds(int d);
    return {7'b1001000, d[4:0], 4'h0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) pmem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_write(string tag, int r, logic [7:0] v);
    step();
    check({tag, " wb_en"}, 32'(wb_en), 32'd1);
    check({tag, " wb_reg"}, 32'(wb_reg), 32'(r));
    check({tag, " wb_val"}, 32'(wb_val), 32'(v));
  endtask

  task automatic expect_idle(string tag);
    step();
    check({tag, " wb_en"}, 32'(wb_en), 32'd0);
  endtask

  task automatic t_reset();
    clear_mem();
    pmem[0] = w_add(0, 1);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 prog_addr in reset", 32'(prog_addr), 32'd0);
    check("R1 flags in reset", 32'(flags), 32'd0);
    check("R1 wb_en in reset", 32'(wb_en), 32'd0);
    check("R1 data_rd in reset", 32'(data_rd), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    expect_write("R1 add R0,R1 after reset", 0, 8'h00);
    check("R1 zero flag", 32'(flags), 32'h02);
  endtask

  task automatic t_ldi();
    clear_mem();
    pmem[0] = w_ldi(16, 8'h3C);
    pmem[1] = w_ldi(31, 8'hA5);
    pmem[2] = w_add(31, 16);
    pmem[3] = w_ldi(20, 8'h00);
    do_reset();
    expect_write("R3 ldi R16", 16, 8'h3C);
    check("R2 pc after ldi", 32'(prog_addr), 32'd1);
    expect_write("R3 ldi R31", 31, 8'hA5);
    check("R9 no data read in fetch", 32'(data_rd), 32'd0);
    expect_write("R4 add R31,R16", 31, 8'hE1);
    check("R5 flags A5+3C", 32'(flags), 32'h14);
    expect_write("R3 ldi R20 zero", 20, 8'h00);
    check("R7 ldi keeps flags", 32'(flags), 32'h14);
    check("R2 pc after four", 32'(prog_addr), 32'd4);
  endtask

  task automatic t_add_case(logic [7:0] a, logic [7:0] b, logic [4:0] fexp);
    clear_mem();
    pmem[0] = w_ldi(16, a);
    pmem[1] = w_ldi(17, b);
    pmem[2] = w_add(16, 17);
    pmem[3] = w_ldi(18, 8'h00);
    pmem[4] = w_add(18, 17);
    do_reset();
    expect_write("R3 ldi a", 16, a);
    expect_write("R3 ldi b", 17, b);
    expect_write("R4 add sum", 16, a + b);
    check("R5 add flags", 32'(flags), 32'(fexp));
    expect_write("R3 ldi clear", 18, 8'h00);
    expect_write("R4 source unchanged", 18, b);
  endtask

  task automatic t_low_regs();
    clear_mem();
    pmem[0] = w_ldi(20, 8'h11);
    pmem[1] = w_add(5, 20);
    pmem[2] = w_add(20, 5);
    pmem[3] = w_add(5, 5);
    pmem[4] = w_ldi(16, 8'h40);
    pmem[5] = w_add(16, 16);
    do_reset();
    expect_write("R3 ldi R20", 20, 8'h11);
    expect_write("R4 add R5,R20", 5, 8'h11);
    expect_write("R4 add R20,R5", 20, 8'h22);
    expect_write("R4 add R5,R5 doubles", 5, 8'h22);
    expect_write("R3 ldi R16", 16, 8'h40);
    expect_write("R4 add R16,R16", 16, 8'h80);
    check("R5 flags 40+40", 32'(flags), 32'h0C);
  endtask

  task automatic t_lds();
    logic [7:0] v1, v2;
    v1 = dval(16'h0123);
    v2 = dval(16'h085F);
    clear_mem();
    pmem[0] = w_ldi(16, 8'h7F);
    pmem[1] = w_ldi(17, 8'h01);
    pmem[2] = w_add(16, 17);
    pmem[3] = w_lds(3);
    pmem[4] = 16'h0123;
    pmem[5] = w_lds(31);
    pmem[6] = 16'h085F;
    pmem[7] = w_add(3, 31);
    do_reset();
    expect_write("R3 ldi 7F", 16, 8'h7F);
    expect_write("R3 ldi 01", 17, 8'h01);
    expect_write("R4 add 7F+01", 16, 8'h80);
    check("R5 flags 7F+01", 32'(flags), 32'h1C);
    expect_idle("R6 lds first word");
    check("R9 no read in cycle 1", 32'(data_rd), 32'd0);
    check("R6 pc after word 1", 32'(prog_addr), 32'd4);
    expect_idle("R6 lds address word");
    check("R6 read strobe", 32'(data_rd), 32'd1);
    check("R6 data address", 32'(data_addr), 32'h0123);
    check("R6 pc after word 2", 32'(prog_addr), 32'd5);
    expect_write("R6 lds R3", 3, v1);
    check("R6 pc held in read", 32'(prog_addr), 32'd5);
    check("R9 read strobe drops", 32'(data_rd), 32'd0);
    check("R7 lds keeps flags", 32'(flags), 32'h1C);
    expect_idle("R6 lds R31 word 1");
    expect_idle("R6 lds R31 word 2");
    check("R6 top SRAM address", 32'(data_addr), 32'h085F);
    expect_write("R6 lds R31", 31, v2);
    check("R6 pc after second load", 32'(prog_addr), 32'd7);
    expect_write("R4 add loaded values", 3, v1 + v2);
  endtask

  task automatic t_nop();
    clear_mem();
    pmem[0] = w_ldi(16, 8'h80);
    pmem[1] = w_ldi(17, 8'h80);
    pmem[2] = w_add(16, 17);
    pmem[3] = 16'hFFFF;
    pmem[4] = 16'h1234;
    pmem[5] = 16'h9001;
    pmem[6] = 16'h9200;
    pmem[7] = 16'h0000;
    pmem[8] = w_ldi(16, 8'h99);
    do_reset();
    expect_write("R3 ldi 80", 16, 8'h80);
    expect_write("R3 ldi 80 b", 17, 8'h80);
    expect_write("R4 add 80+80", 16, 8'h00);
    check("R5 flags 80+80", 32'(flags), 32'h0B);
    for (int i = 0; i < 5; i++) begin
      expect_idle("R8 unknown word");
      check("R8 pc advances one", 32'(prog_addr), 32'(4 + i));
      check("R8 flags kept", 32'(flags), 32'h0B);
      check("R9 no read on no-op", 32'(data_rd), 32'd0);
    end
    expect_write("R10 write after no-ops", 16, 8'h99);
  endtask

  task automatic t_wrap();
    int n;
    clear_mem();
    do_reset();
    n = 0;
    while (prog_addr != 14'h3FFF && n < 20000) begin
      step();
      n++;
    end
    check("R2 pc reaches top", 32'(prog_addr), 32'h3FFF);
    step();
    check("R2 pc wraps to zero", 32'(prog_addr), 32'd0);
    check("R10 no writes on no-ops", 32'(wb_en), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_ldi();
    t_add_case(8'h3C, 8'h05, 5'h10);
    t_add_case(8'h80, 8'h80, 5'h0B);
    t_add_case(8'h7F, 8'h01, 5'h1C);
    t_add_case(8'hFF, 8'h01, 5'h13);
    t_low_regs();
    t_lds();
    t_nop();
    t_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule